// File: doc/BRIEF.md
# Coprocessor Control Register Bank with Busy Handshake

This block models the control port of an audio coprocessor as a bank of sixteen 16-bit registers. A host starts one read or write at a time through a parallel request, direction, address and data interface. The block takes the request in a single cycle. It then keeps its ready output high for a short detection interval. After that it drives ready low for a processing interval that depends on the register and on the direction of the access. When that interval ends, ready goes high again. Writes take effect on the cycle the request is taken. Read data is captured on the same cycle and is held on the data output until the next read.

The bank keeps its own reset values and ignores writes to the two read-only header registers. After every reset, a built-in sequence rewrites the status register twice. A write to the mode register can also request a software reset. That write holds ready low for a long interval and then returns every register to its reset value. A side input marks a full data buffer and holds ready low for as long as it is asserted, so an operation that ends while the buffer is full still leaves ready low. A request that arrives while an earlier one is still in progress is ignored and reported on an error output. All durations are counted in clk_i cycles.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, register 0x0 reads 0x4800, register 0x1 reads 0x000C, and every other register reads 0x0000.
- R2: On the 8th rising clock edge after reset release (or after a software reset completes), register 0x1 becomes 0x0048. On the 64th edge it becomes 0x0040. These updates take priority over a host write to 0x1 on the same edge.
- R3: A request is accepted on a rising edge where req_i is high and no operation is in progress. A write (we_i=1) updates the addressed register on that edge. A read (we_i=0) loads rdata_o on that edge with the register value from before the edge, and rdata_o holds it until the next accepted read.
- R4: Registers 0x8 and 0x9 are read-only. A write to them leaves them unchanged but still uses the normal write timing.
- R5: After an accept, ready_o stays high for a detection delay: 16 cycles, or 40 cycles when irq_act_i is high on the accepting edge.
- R6: After the detection delay, a write drives ready_o low for this many cycles: 1200 for 0x3, 100 for 0x4, 0x6 and 0x7, 450 for 0x5, 210 for 0xA, and 80 for every other address.
- R7: After the detection delay, a read drives ready_o low for 200 cycles when the address is 0xA and for 80 cycles otherwise.
- R8: A write to 0x0 with bit 2 set drives ready_o low for 22000 cycles instead of 80. On the edge where that interval ends, every register returns to its R1 value and the R2 sequence starts again.
- R9: While buf_full_i is high, ready_o is low. Once no operation is in progress and buf_full_i is low, ready_o is high.
- R10: A request on an edge where an operation is in progress has no effect on the registers or on the timing, and busy_err_o is high for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| irq_act_i | input | 1 | Selects the long detection delay |
| buf_full_i | input | 1 | Data buffer full; holds ready low |
| rdata_o | output | 16 | Read data from the last accepted read |
| ready_o | output | 1 | Data-request / ready, active high |
| busy_err_o | output | 1 | Pulse: a request arrived while busy |

## Verification
The host port is exercised with reads and writes to every address, so that each member of the duration table is checked on its own. Accesses are run with the interrupt flag both low and high, which separates the two detection delays. A second request issued in the middle of a busy interval shows whether it is really ignored. A buffer-full pulse that straddles the end of an interval shows whether ready follows the side input or the internal timer. A software reset, followed by reads placed between the two status updates, tells the mode-write duration apart from the other write durations and shows the restart of the status sequence.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int unsigned NREG = 16;
  localparam int unsigned AW   = $clog2(NREG);
  localparam int unsigned DW   = 16;

  localparam logic [AW-1:0] A_MODE = 4'h0;
  localparam logic [AW-1:0] A_STAT = 4'h1;
  localparam logic [AW-1:0] A_CLK  = 4'h3;
  localparam logic [AW-1:0] A_DTIM = 4'h4;
  localparam logic [AW-1:0] A_AUD  = 4'h5;
  localparam logic [AW-1:0] A_RAMD = 4'h6;
  localparam logic [AW-1:0] A_RAMA = 4'h7;
  localparam logic [AW-1:0] A_HDA  = 4'h8;
  localparam logic [AW-1:0] A_HDB  = 4'h9;
  localparam logic [AW-1:0] A_APPA = 4'hA;

  localparam logic [DW-1:0] MODE_RST = 16'h4800;
  localparam logic [DW-1:0] STAT_RST = 16'h000C;
  localparam logic [DW-1:0] STAT_A   = 16'h0048;
  localparam logic [DW-1:0] STAT_B   = 16'h0040;
  localparam int unsigned   SRST_BIT = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_DET, PH_HOLD} phase_e;

  function automatic logic [DW-1:0] rst_val(input logic [AW-1:0] a);
    case (a)
      A_MODE:  return MODE_RST;
      A_STAT:  return STAT_RST;
      default: return '0;
    endcase
  endfunction

  function automatic logic is_ro(input logic [AW-1:0] a);
    return (a == A_HDA) || (a == A_HDB);
  endfunction
endpackage

// File: rtl/ctl_stat_seq.sv
module ctl_stat_seq #(
  parameter int unsigned T_A = 8,
  parameter int unsigned T_B = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic upd_a_o,
  output logic upd_b_o
);
  localparam int unsigned CW = $clog2(T_B + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q < CW'(T_B))  cnt_q <= cnt_q + 1'b1;
  end

  assign upd_a_o = !restart_i && (cnt_q == CW'(T_A - 1));
  assign upd_b_o = !restart_i && (cnt_q == CW'(T_B - 1));
endmodule

// File: rtl/ctl_busy_timer.sv
module ctl_busy_timer
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] det_i,
  input  logic [CW-1:0] dur_i,
  input  logic          srst_i,
  output logic          busy_o,
  output logic          hold_o,
  output logic          srst_done_o
);
  phase_e        ph_q;
  logic [CW-1:0] cnt_q, dur_q;
  logic          srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      dur_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_DET;
          cnt_q  <= det_i - 1'b1;
          dur_q  <= dur_i;
          srst_q <= srst_i;
        end
        PH_DET: if (cnt_q == '0) begin
          ph_q  <= PH_HOLD;
          cnt_q <= dur_q - 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          ph_q   <= PH_IDLE;
          srst_q <= 1'b0;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (ph_q != PH_IDLE);
  assign hold_o      = (ph_q == PH_HOLD);
  assign srst_done_o = hold_o && (cnt_q == '0) && srst_q;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          srst_i,
  input  logic          stat_a_i,
  input  logic          stat_b_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= rst_val(AW'(i));
    end else if (srst_i) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= rst_val(AW'(i));
    end else begin
      if (wr_en_i && !is_ro(addr_i)) regs_q[addr_i] <= wdata_i;
      // status sequence overrides a host write on the same edge
      if (stat_a_i) regs_q[A_STAT] <= STAT_A;
      if (stat_b_i) regs_q[A_STAT] <= STAT_B;
    end
  end

  assign rdata_o = regs_q[addr_i];
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned T_DET      = 16,
  parameter int unsigned T_DET_IRQ  = 40,
  parameter int unsigned T_WR       = 80,
  parameter int unsigned T_WR_MID   = 100,
  parameter int unsigned T_WR_AUD   = 450,
  parameter int unsigned T_WR_APPA  = 210,
  parameter int unsigned T_WR_CLK   = 1200,
  parameter int unsigned T_SRST     = 22000,
  parameter int unsigned T_RD       = 80,
  parameter int unsigned T_RD_APPA  = 200,
  parameter int unsigned T_STAT_A   = 8,
  parameter int unsigned T_STAT_B   = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [15:0]   wdata_i,
  input  logic          irq_act_i,
  input  logic          buf_full_i,
  output logic [15:0]   rdata_o,
  output logic          ready_o,
  output logic          busy_err_o
);
  localparam int unsigned CW = $clog2(T_SRST + T_WR_CLK + T_WR_AUD + T_DET_IRQ + 1);

  logic          busy, hold, acc, srst_done, upd_a, upd_b;
  logic [CW-1:0] dur, det;
  logic [DW-1:0] reg_rd;
  logic          srst_req;

  assign acc      = req_i && !busy;
  assign srst_req = we_i && (addr_i == A_MODE) && wdata_i[SRST_BIT];
  assign det      = irq_act_i ? CW'(T_DET_IRQ) : CW'(T_DET);

  always_comb begin
    if (!we_i) dur = (addr_i == A_APPA) ? CW'(T_RD_APPA) : CW'(T_RD);
    else if (srst_req) dur = CW'(T_SRST);
    else begin
      case (addr_i)
        A_CLK:                 dur = CW'(T_WR_CLK);
        A_DTIM, A_RAMD, A_RAMA: dur = CW'(T_WR_MID);
        A_AUD:                 dur = CW'(T_WR_AUD);
        A_APPA:                dur = CW'(T_WR_APPA);
        default:               dur = CW'(T_WR);
      endcase
    end
  end

  ctl_busy_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni,
    .start_i(acc), .det_i(det), .dur_i(dur), .srst_i(srst_req),
    .busy_o(busy), .hold_o(hold), .srst_done_o(srst_done)
  );

  ctl_stat_seq #(.T_A(T_STAT_A), .T_B(T_STAT_B)) u_seq (
    .clk_i, .rst_ni, .restart_i(srst_done), .upd_a_o(upd_a), .upd_b_o(upd_b)
  );

  ctl_regfile u_rf (
    .clk_i, .rst_ni,
    .wr_en_i(acc && we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .srst_i(srst_done), .stat_a_i(upd_a), .stat_b_i(upd_b),
    .rdata_o(reg_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      busy_err_o <= 1'b0;
    end else begin
      if (acc && !we_i) rdata_o <= reg_rd;
      busy_err_o <= req_i && busy;
    end
  end

  assign ready_o = !buf_full_i && !hold;
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [3:0]  addr_i,
  input logic        buf_full_i,
  input logic [15:0] rdata_o,
  input logic        ready_o,
  input logic        busy_err_o,
  input logic        acc,
  input logic        busy
);
  // R9
  full_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_i |-> !ready_o);
  // R9
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !buf_full_i) |-> ready_o);
  // R10
  err_after_busy_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy) |=> busy_err_o);
  // R10
  err_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |-> $past(req_i));
  // R5
  det_keeps_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (ready_o || buf_full_i));
  // R4
  ro_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !we_i && (addr_i == 4'h8 || addr_i == 4'h9)) |=> (rdata_o == 16'h0));
endmodule

bind ctl_regbank ctl_regbank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .buf_full_i(buf_full_i), .rdata_o(rdata_o), .ready_o(ready_o),
  .busy_err_o(busy_err_o), .acc(acc), .busy(busy)
);

// File: tb/tb_ctl_regbank.sv
`timescale 1ns/1ps
module tb_ctl_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, irq = 1'b0, full = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ready, berr;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctl_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .irq_act_i(irq), .buf_full_i(full),
    .rdata_o(rdata), .ready_o(ready), .busy_err_o(berr)
  );

  // behavioural reference model
  logic [15:0] m_reg [16];
  logic [15:0] m_rd;
  bit m_busy, m_srst, m_err;
  int t, det, dur, sc;

  function automatic logic [15:0] rv(int a);
    return a == 0 ? 16'h4800 : a == 1 ? 16'h000C : 16'h0000;
  endfunction

  function automatic int wr_time(int a, logic [15:0] d);
    if (a == 0 && d[2]) return 22000;          // R8
    if (a == 3) return 1200;                   // R6
    if (a == 4 || a == 6 || a == 7) return 100;
    if (a == 5) return 450;
    if (a == 10) return 210;
    return 80;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = rv(i);
    m_rd = '0; m_busy = 0; m_srst = 0; m_err = 0; t = 0; det = 0; dur = 0; sc = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit was_busy;
      was_busy = m_busy;
      m_err = req && was_busy;
      if (!was_busy && req) begin
        det = irq ? 40 : 16;                     // R5
        t = 0; m_busy = 1;
        m_srst = we && addr == 0 && wdata[2];
        if (we) begin
          dur = wr_time(addr, wdata);
          if (addr != 8 && addr != 9) m_reg[addr] = wdata;   // R4
        end else begin
          dur = (addr == 10) ? 200 : 80;           // R7
          m_rd = m_reg[addr];
        end
      end
      if (sc < 64) begin
        sc++;
        if (sc == 8)  m_reg[1] = 16'h0048;         // R2
        if (sc == 64) m_reg[1] = 16'h0040;
      end
      if (was_busy) begin
        t++;
        if (t == det + dur) begin
          m_busy = 0;
          if (m_srst) begin
            for (int i = 0; i < 16; i++) m_reg[i] = rv(i);
            sc = 0; m_srst = 0;
          end
        end
      end
    end
  end

  task automatic chk(string r, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", r, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #1;
    cycles++;
    if (rst_n && !done) begin
      chk(tag, "ready_o", {15'b0, ready}, {15'b0, !full && !(m_busy && t >= det)});
      chk("R10", "busy_err_o", {15'b0, berr}, {15'b0, m_err});
      chk("R3", "rdata_o", rdata, m_rd);
    end
  end

  task automatic op(bit w, int a, logic [15:0] d, bit i = 0);
    @(negedge clk);
    req = 1; we = w; addr = a[3:0]; wdata = d; irq = i;
    @(negedge clk);
    req = 0; we = 0; irq = 0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(int a, logic [15:0] exp, string r);
    op(0, a, '0);
    wait_idle();
    chk(r, $sformatf("read reg %0d", a), rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    tag = "R1";
    chk("R1", "ready after reset", {15'b0, ready}, 16'h1);
    rd(1, 16'h000C, "R1");
    rd(0, 16'h4800, "R1");
    rd(2, 16'h0000, "R1");
    // R2 status settled
    tag = "R2";
    rd(1, 16'h0040, "R2");
    // R3 R6 R4 writes to every address
    tag = "R6";
    for (int a = 1; a < 16; a++) begin
      op(1, a, 16'hA5A5 ^ (16'h1111 * a[15:0]));
      wait_idle();
    end
    tag = "R3";
    rd(2, 16'hA5A5 ^ 16'h2222, "R3");
    rd(15, 16'hA5A5 ^ 16'hFFFF, "R3");
    rd(8, 16'h0000, "R4");
    rd(9, 16'h0000, "R4");
    // R5 long detection delay
    tag = "R5";
    op(1, 11, 16'h0BEE, 1);
    wait_idle();
    op(0, 11, '0, 1);
    wait_idle();
    chk("R5", "read with irq", rdata, 16'h0BEE);
    // R7 slow read address
    tag = "R7";
    rd(10, 16'hA5A5 ^ 16'hAAAA, "R7");
    // R10 request while busy is dropped
    tag = "R10";
    op(1, 2, 16'h5555);
    repeat (5) @(negedge clk);
    op(1, 2, 16'h9999);
    wait_idle();
    rd(2, 16'h5555, "R10");
    // R9 buffer full straddling the end of a busy interval
    tag = "R9";
    op(1, 12, 16'h0C0C);
    repeat (60) @(negedge clk);
    full = 1;
    repeat (80) @(negedge clk);
    chk("R9", "ready held low by full", {15'b0, ready}, 16'h0);
    full = 0;
    wait_idle();
    // R8 software reset
    tag = "R8";
    op(1, 0, 16'h4804);
    repeat (20000) @(negedge clk);
    chk("R8", "still busy in reset", {15'b0, ready}, 16'h0);
    wait_idle();
    repeat (10) @(negedge clk);
    rd(1, 16'h0048, "R8");
    rd(2, 16'h0000, "R8");
    rd(0, 16'h4800, "R8");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule